// File: doc/BRIEF.md
# SPI Command and Status Shifter

This block is the serial front end of a multi-channel output controller. A host frames each transfer with an active-low chip select. When the select falls, the block takes a snapshot of the latched fault flags and a few direct input pins and loads it into a 16-bit shifter. The snapshot goes out on SO, most significant bit first, while the host's command word shifts in on SI. If the host keeps clocking past 16 bits, SO returns the SI bits it received, 16 bits late. Several devices can therefore be chained on one select line.

When the select rises, the block counts the bits it received. It accepts the frame only if that count is a nonzero multiple of 16. In that case the last 16 bits form the command: bit 15 is a watchdog bit, bits 14:12 are a register address, and bits 11:0 are data. The address picks one of three configuration registers. The watchdog bit is kept and reported at the top of the next status word.

The serial pins are treated as signals synchronous to a faster system clock. The block finds their edges by comparing each pin with its value one clock earlier. SI is sampled on rising SCLK and SO changes on falling SCLK (SPI mode 0).

Top module: `spi_cmd_status_shifter`

## Requirements
- R1: After reset so_oe is 0, wdog_bit is 0, and cfg_wdcs, cfg_openload and cfg_ilim are all zero.
- R2: so_oe is 0 in the clock after cs_n is sampled high. It becomes 1 only in the clock after cs_n is sampled low.
- R3: When cs_n falls, a 16-bit status word is loaded and sent MSB first. Its bit 15 equals the watchdog bit (command bit 15) of the most recent accepted frame, or 0 if no frame has been accepted since reset.
- R4: Status bits 14:12 are {drv_in[0], drv_in[1], safe_in} when status bit 15 is 0. They are {drv_in[2], drv_in[3], wake_in} when it is 1.
- R5: Status bits 11:0 report fault_in[11:0]. A bit is 1 if that fault input was high at any clock while cs_n was high before the snapshot, or is high at the snapshot. Reporting a flag clears it. A fault that stays present is reported again in the next frame.
- R6: SI is sampled on rising SCLK. SO changes only on falling SCLK, apart from the load when cs_n falls.
- R7: In a frame longer than 16 bits, SO bit number n (n ≥ 16, counting from 0) equals the SI bit received at position n−16.
- R8: On cs_n rising, the frame is accepted only if the number of rising SCLK edges is a nonzero multiple of 16. Otherwise no register and not wdog_bit change. In a longer frame the last 16 bits received are the command.
- R9: An accepted command with address 3'b110 loads data bits 11:0 into cfg_wdcs. Address 3'b001 loads cfg_openload and address 3'b101 loads cfg_ilim. Every accepted command loads its bit 15 into wdog_bit.
- R10: An accepted command with any other address, including 3'b011 and 3'b111, leaves all three configuration registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low frame select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so (tristate control) |
| fault_in | input | 12 | Per-channel fault indications |
| drv_in | input | 4 | Direct drive input pins, reported in the status word |
| safe_in | input | 1 | Fail-safe input pin, reported when status bit 15 is 0 |
| wake_in | input | 1 | Wake input pin, reported when status bit 15 is 1 |
| wdog_bit | output | 1 | Watchdog bit from the last accepted command |
| cfg_wdcs | output | 12 | Watchdog and current-sense configuration |
| cfg_openload | output | 12 | Open-load detection configuration |
| cfg_ilim | output | 12 | Current-limit and overcurrent configuration |

## Verification
On every cycle, the assertions check the output-enable timing against chip select. They check that the first status bit matches the held watchdog bit, and that SO moves only on falling SCLK. They also check that configuration state changes only in the clock where chip select is seen rising. The bench scenarios cover everything that depends on frame content. That includes the pin multiplexing for both watchdog values and the reporting and clearing of short and persistent faults. It also includes the 16-bit echo in a 32-bit chained frame, the rejection of 15-bit, 17-bit and empty frames, and the handling of unused and test addresses.

// File: rtl/scs_pkg.sv
package scs_pkg;
   localparam int WORD_W  = 16;
   localparam int ADDR_W  = 3;
   localparam int DATA_W  = 12;
   localparam int NUM_CFG = 3;
   localparam logic [ADDR_W-1:0] A_WDCS = 3'b110;
   localparam logic [ADDR_W-1:0] A_OPEN = 3'b001;
   localparam logic [ADDR_W-1:0] A_ILIM = 3'b101;
   // slot 0 in the low bits
   localparam logic [NUM_CFG*ADDR_W-1:0] CFG_ADDRS = {A_ILIM, A_OPEN, A_WDCS};
endpackage

// File: rtl/scs_edge.sv
module scs_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic cs_fall,
   output logic cs_rise,
   output logic cs_idle
);
   logic sclk_s, cs_s, sclk_q, cs_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign sclk_s = sclk;
         assign cs_s   = cs_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sc, cc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sc <= '0;
               cc <= '1;
            end else begin
               sc[0] <= sclk;
               cc[0] <= cs_n;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  sc[i] <= sc[i-1];
                  cc[i] <= cc[i-1];
               end
            end
         end
         assign sclk_s = sc[SYNC_STAGES-1];
         assign cs_s   = cc[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         cs_q   <= 1'b1;
      end else begin
         sclk_q <= sclk_s;
         cs_q   <= cs_s;
      end
   end

   assign cs_fall   = cs_q & ~cs_s;
   assign cs_rise   = ~cs_q & cs_s;
   assign cs_idle   = cs_q;
   assign sclk_rise = ~cs_q & ~cs_s & sclk_s & ~sclk_q;
   assign sclk_fall = ~cs_q & ~cs_s & ~sclk_s & sclk_q;
endmodule

// File: rtl/scs_status.sv
module scs_status #(
   parameter int FAULT_W = 12,
   localparam int STAT_W = FAULT_W + 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               collect,
   input  logic               snap,
   input  logic [FAULT_W-1:0] fault_in,
   input  logic               wd_prev,
   input  logic [3:0]         drv_in,
   input  logic               safe_in,
   input  logic               wake_in,
   output logic [STAT_W-1:0]  status_word
);
   logic [FAULT_W-1:0] flags;
   logic [2:0]         pins;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flags <= '0;
      else if (snap)    flags <= '0;
      else if (collect) flags <= flags | fault_in;
   end

   assign pins = wd_prev ? {drv_in[2], drv_in[3], wake_in}
                         : {drv_in[0], drv_in[1], safe_in};
   assign status_word = {wd_prev, pins, flags | fault_in};
endmodule

// File: rtl/scs_frame.sv
module scs_frame #(
   parameter int WORD_W = 16,
   localparam int CNT_W = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              si,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic              cs_fall,
   input  logic              cs_rise,
   input  logic [WORD_W-1:0] load_word,
   output logic              so,
   output logic [WORD_W-1:0] cmd,
   output logic              commit
);
   logic [WORD_W-1:0] sh;
   logic [CNT_W-1:0]  cnt;
   logic              full_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh        <= '0;
         cnt       <= '0;
         full_seen <= 1'b0;
         so        <= 1'b0;
      end else if (cs_fall) begin
         sh        <= load_word;
         so        <= load_word[WORD_W-1];
         cnt       <= '0;
         full_seen <= 1'b0;
      end else begin
         if (sclk_rise) begin
            sh  <= {sh[WORD_W-2:0], si};
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(WORD_W-1)) full_seen <= 1'b1;
         end
         if (sclk_fall) so <= sh[WORD_W-1];
      end
   end

   assign cmd    = sh;
   assign commit = cs_rise & full_seen & (cnt == '0);
endmodule

// File: rtl/scs_cfg_bank.sv
module scs_cfg_bank #(
   parameter int ADDR_W  = 3,
   parameter int DATA_W  = 12,
   parameter int NUM_CFG = 3,
   parameter logic [NUM_CFG*ADDR_W-1:0] ADDRS = '0,
   localparam int WORD_W = 1 + ADDR_W + DATA_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      commit,
   input  logic [WORD_W-1:0]         cmd,
   output logic                      wd_bit,
   output logic [NUM_CFG*DATA_W-1:0] cfg
);
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] data;
   assign addr = cmd[DATA_W +: ADDR_W];
   assign data = cmd[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wd_bit <= 1'b0;
      else if (commit) wd_bit <= cmd[WORD_W-1];
   end

   generate
      for (genvar g = 0; g < NUM_CFG; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cfg[g*DATA_W +: DATA_W] <= '0;
            else if (commit && addr == ADDRS[g*ADDR_W +: ADDR_W])
               cfg[g*DATA_W +: DATA_W] <= data;
         end
      end
   endgenerate
endmodule

// File: rtl/spi_cmd_status_shifter.sv
module spi_cmd_status_shifter
   import scs_pkg::*;
#(
   parameter int FAULT_W     = DATA_W,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk,
   input  logic               cs_n,
   input  logic               si,
   output logic               so,
   output logic               so_oe,
   input  logic [FAULT_W-1:0] fault_in,
   input  logic [3:0]         drv_in,
   input  logic               safe_in,
   input  logic               wake_in,
   output logic               wdog_bit,
   output logic [DATA_W-1:0]  cfg_wdcs,
   output logic [DATA_W-1:0]  cfg_openload,
   output logic [DATA_W-1:0]  cfg_ilim
);
   generate
      if (FAULT_W + 4 != WORD_W) begin : g_bad_fault
         $error("fault width must fill the status word");
      end
      if (1 + ADDR_W + DATA_W != WORD_W) begin : g_bad_cmd
         $error("command fields must fill the word");
      end
   endgenerate

   logic sclk_rise, sclk_fall, cs_fall, cs_rise, cs_idle, commit;
   logic [WORD_W-1:0]         status_word, cmd;
   logic [NUM_CFG*DATA_W-1:0] cfg_all;

   scs_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
      .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
      .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_idle(cs_idle));

   scs_status #(.FAULT_W(FAULT_W)) u_status (
      .clk(clk), .rst_n(rst_n), .collect(cs_idle), .snap(cs_fall),
      .fault_in(fault_in), .wd_prev(wdog_bit), .drv_in(drv_in),
      .safe_in(safe_in), .wake_in(wake_in), .status_word(status_word));

   scs_frame #(.WORD_W(WORD_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .si(si), .sclk_rise(sclk_rise),
      .sclk_fall(sclk_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
      .load_word(status_word), .so(so), .cmd(cmd), .commit(commit));

   scs_cfg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CFG(NUM_CFG),
                  .ADDRS(CFG_ADDRS)) u_bank (
      .clk(clk), .rst_n(rst_n), .commit(commit), .cmd(cmd),
      .wd_bit(wdog_bit), .cfg(cfg_all));

   assign so_oe        = ~cs_idle;
   assign cfg_wdcs     = cfg_all[0*DATA_W +: DATA_W];
   assign cfg_openload = cfg_all[1*DATA_W +: DATA_W];
   assign cfg_ilim     = cfg_all[2*DATA_W +: DATA_W];
endmodule

// File: rtl/scs_chk.sv
module scs_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cs_n,
   input logic        sclk,
   input logic        so,
   input logic        so_oe,
   input logic        wdog_bit,
   input logic [11:0] cfg_wdcs,
   input logic [11:0] cfg_openload,
   input logic [11:0] cfg_ilim
);
   // R2
   oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !so_oe);

   // R2
   oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(so_oe) |-> !$past(cs_n));

   // R3
   msb_wd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(so_oe) |-> so == wdog_bit);

   // R6
   so_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (so_oe && $past(so_oe) && !$stable(so)) |-> !$past(sclk));

   // R8
   cfg_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cfg_wdcs) || !$stable(cfg_openload) || !$stable(cfg_ilim)
       || !$stable(wdog_bit)) |-> ($past(cs_n) && $past(so_oe)));
endmodule

bind spi_cmd_status_shifter scs_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .so(so),
   .so_oe(so_oe), .wdog_bit(wdog_bit), .cfg_wdcs(cfg_wdcs),
   .cfg_openload(cfg_openload), .cfg_ilim(cfg_ilim));

// File: tb/sim_spi_cmd_status_shifter.sv
`timescale 1ns/1ps
module sim_spi_cmd_status_shifter;
   logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, si = 1'b0;
   logic so, so_oe, wdog_bit, safe_in = 1'b0, wake_in = 1'b0;
   logic [11:0] fault_in = '0, cfg_wdcs, cfg_openload, cfg_ilim;
   logic [3:0]  drv_in = '0;
   int vectors = 0, miscompares = 0;
   bit done = 0;
   logic  exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   spi_cmd_status_shifter u0 (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si),
      .so(so), .so_oe(so_oe), .fault_in(fault_in), .drv_in(drv_in),
      .safe_in(safe_in), .wake_in(wake_in), .wdog_bit(wdog_bit),
      .cfg_wdcs(cfg_wdcs), .cfg_openload(cfg_openload), .cfg_ilim(cfg_ilim));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   // monitor: SO is sampled at each rising SCLK, well after its falling-edge update (R6)
   always @(posedge sclk) begin
      if (!cs_n) begin
         chk("R2 so_oe in frame", so_oe, 1);
         if (exp_q.size() == 0) chk("scoreboard empty", 1, 0);
         else chk(tag_q.pop_front(), so, exp_q.pop_front());
      end
   end

   // driver: frame of nbits, SI bits taken MSB first from bits[nbits-1:0]
   task automatic frame(input int nbits, input logic [31:0] bits, input logic [15:0] stat);
      logic [31:0] sent = '0;
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         si = bits[nbits-1-i];
         sent[i] = si;
         repeat (4) @(negedge clk);
         if (i < 16) begin
            exp_q.push_back(stat[15-i]);
            tag_q.push_back(i == 0 ? "R3 status bit15" : (i < 4 ? "R4 pin bits" : "R5 fault bits"));
         end else begin
            exp_q.push_back(sent[i-16]);
            tag_q.push_back("R7 daisy echo");
         end
         sclk = 1'b1;
         repeat (4) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (4) @(negedge clk);
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
      chk("R2 so_oe idle", so_oe, 0);
   endtask

   task automatic regs(input string req, input logic wd, input logic [11:0] a,
                       input logic [11:0] b, input logic [11:0] c);
      chk(req, {wdog_bit, cfg_wdcs, cfg_openload, cfg_ilim}, {wd, a, b, c});
   endtask

   initial begin
      #(200000 * 5);
      chk("watchdog expired", 1, 0);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      regs("R1 reset", 0, 0, 0, 0);
      chk("R1 so_oe reset", so_oe, 0);
      rst_n = 1'b1;
      drv_in = 4'b1010; safe_in = 1'b1; wake_in = 1'b0;
      fault_in[3] = 1'b1;
      repeat (2) @(negedge clk);
      fault_in[3] = 1'b0; fault_in[9] = 1'b1;
      repeat (3) @(negedge clk);
      // A: pulse on 3 and steady 9 reported; address 110 written
      frame(16, 32'hE035, 16'h3208);
      regs("R9 write 110", 1, 12'h035, 0, 0);
      // B: pulse flag cleared, persistent fault repeated; mux with bit15=1
      frame(16, 32'h1ABC, 16'hA200);
      regs("R9 write 001", 0, 12'h035, 12'hABC, 0);
      // C: 15 bits rejected
      frame(15, 32'h5111, 16'h3200);
      regs("R8 15-bit frame", 0, 12'h035, 12'hABC, 0);
      fault_in = '0;
      // D: 17 bits rejected; fault 9 latched while idle
      frame(17, 32'h1D111, 16'h3200);
      regs("R8 17-bit frame", 0, 12'h035, 12'hABC, 0);
      // E: chained 32-bit frame, last word commits to 101
      frame(32, 32'hFFFF_D5A5, 16'h3000);
      regs("R8 last word of 32", 1, 12'h035, 12'hABC, 12'h5A5);
      // F: unused address 011
      frame(16, 32'h3777, 16'hA000);
      regs("R10 addr 011", 0, 12'h035, 12'hABC, 12'h5A5);
      // G: test address 111
      frame(16, 32'hF123, 16'h3000);
      regs("R10 addr 111", 1, 12'h035, 12'hABC, 12'h5A5);
      // H: empty frame
      frame(0, 32'h0, 16'h0);
      regs("R8 empty frame", 1, 12'h035, 12'hABC, 12'h5A5);
      // I: new pin values on the bit15=1 selection
      drv_in = 4'b0101; safe_in = 1'b0; wake_in = 1'b1;
      frame(16, 32'h60F0, 16'hD000);
      regs("R9 rewrite 110", 0, 12'h0F0, 12'hABC, 12'h5A5);
      chk("scoreboard drained", exp_q.size(), 0);
      summary();
   end
endmodule